// File: doc/BRIEF.md
# Double-Buffered Compare Waveform Channel

This block is one compare channel of a timer. It keeps two compare registers. Software writes the buffer register. The active register is the one that is compared with the counter. The counter, its direction and a count-tick enable come from the timer core. Each tick where the counter equals the active value is a match.

A match sets a sticky flag, which feeds a gated interrupt request. A match can also emit a one-cycle event pulse. It toggles a waveform state bit, and that bit leaves the block through an optional inverter.

The buffer value moves into the active register only at the end of a counting period, or when a force command arrives. A compare change therefore never lands in the middle of a period, and the output has no short or lopsided pulses. In normal-frequency mode the period is set by the external top value. In match-frequency mode the period is set by the channel's own active compare value, which is also reported on the period output.

Top module: `cmp_wave_chan`

## Requirements
- R1: After reset the active value, the buffer value, the match flag, the event output and the waveform state are all 0. The channel starts in compare operation.
- R2: Writing the buffer (`buf_we`) leaves `cc_active` unchanged until an update point or a force command. A transfer copies the buffer content held before that clock edge, so a write in the same cycle is not included.
- R3: `cmd` equal to 2'b11 copies the buffer into the active value at that edge. Every other `cmd` code has no effect.
- R4: An update point is a tick with `cnt_down`=0 and `cnt_val` equal to the period, or a tick with `cnt_down`=1 and `cnt_val` equal to 0. Reaching the period while counting down is not an update point.
- R5: `wave_mode`=0 (normal frequency) makes the period `top_val`. `wave_mode`=1 (match frequency) makes the period the active compare value. `period` shows the value in use.
- R6: A match is `cnt_tick`=1 with `cnt_val` equal to `cc_active`. `match_flag` is 1 from the clock edge at which the match is seen. When `cnt_tick`=0 there is no match.
- R7: `flag_clr`=1 clears `match_flag` at the next edge. A match in the same cycle wins, and the flag stays 1.
- R8: `irq` is `match_flag` gated by `int_en`. `evt_out` is 1 for exactly the cycle after each match edge, and only when `evt_en`=1.
- R9: The waveform state toggles on every match. `wave_out` is that state XOR `wave_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | Counter advanced this cycle |
| cnt_val | input | W | Counter value |
| cnt_down | input | 1 | Counter direction, 1 = down |
| top_val | input | W | Counter top value |
| buf_we | input | 1 | Buffer write strobe |
| buf_wdata | input | W | Buffer write data |
| cmd | input | 2 | Command code, 2'b11 = force update |
| wave_mode | input | 1 | 0 normal frequency, 1 match frequency |
| flag_clr | input | 1 | Write-1 clear of the match flag |
| int_en | input | 1 | Interrupt enable |
| evt_en | input | 1 | Event output enable |
| wave_inv | input | 1 | Waveform output inversion |
| cc_active | output | W | Active compare value |
| period | output | W | Period in use |
| match_flag | output | 1 | Sticky match flag |
| irq | output | 1 | Interrupt request |
| evt_out | output | 1 | Match event pulse |
| wave_out | output | 1 | Waveform output |

## Verification
The assertions assume that the counter, its direction and the tick are each settled for a whole cycle and change only between edges. They also assume that `cmd` carries a code for one cycle, so one edge sees it once. The bench drives every input on the falling edge and holds it until the next falling edge, and it gives the force code for a single step. The counter values come from a table and do not follow a free-running counter. This lets each update point, down-count boundary and mode switch be placed deliberately, while each input stays constant across its sampling edge.

// File: rtl/cmp_wave_chan.sv
module cmp_wave_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_tick,
  input  logic [W-1:0] cnt_val,
  input  logic         cnt_down,
  input  logic [W-1:0] top_val,
  input  logic         buf_we,
  input  logic [W-1:0] buf_wdata,
  input  logic [1:0]   cmd,
  input  logic         wave_mode,
  input  logic         flag_clr,
  input  logic         int_en,
  input  logic         evt_en,
  input  logic         wave_inv,
  output logic [W-1:0] cc_active,
  output logic [W-1:0] period,
  output logic         match_flag,
  output logic         irq,
  output logic         evt_out,
  output logic         wave_out
);
  localparam logic [1:0] CMD_FORCE = 2'b11;

  logic [W-1:0] cc_q, buf_q;
  logic         flag_q, evt_q, wave_q;
  logic         match, upd, force_cmd;

  assign period    = wave_mode ? cc_q : top_val;
  assign match     = cnt_tick && (cnt_val == cc_q);
  assign upd       = cnt_tick && (cnt_down ? (cnt_val == '0) : (cnt_val == period));
  assign force_cmd = (cmd == CMD_FORCE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cc_q   <= '0;
      buf_q  <= '0;
      flag_q <= 1'b0;
      evt_q  <= 1'b0;
      wave_q <= 1'b0;
    end else begin
      if (buf_we) buf_q <= buf_wdata;
      if (upd || force_cmd) cc_q <= buf_q;
      if (match) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      evt_q <= match && evt_en;
      if (match) wave_q <= ~wave_q;
    end
  end

  assign cc_active  = cc_q;
  assign match_flag = flag_q;
  assign irq        = flag_q && int_en;
  assign evt_out    = evt_q;
  assign wave_out   = wave_q ^ wave_inv;

  a_r2_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd || force_cmd) |=> $stable(cc_q));
  a_r3_force_copies: assert property (@(posedge clk) disable iff (!rst_n)
    force_cmd |=> cc_q == $past(buf_q));
  a_r6_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> match_flag);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !match) |=> !match_flag);
  a_r8_evt_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_en |=> !evt_out);
  a_r9_wave_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> wave_q != $past(wave_q));
endmodule

// File: tb/test_cmp_wave_chan.sv
`timescale 1ns/1ps
module test_cmp_wave_chan;
  localparam int W = 16;
  localparam logic [W-1:0] TOP = 16'd100;

  typedef struct packed {
    logic         we;
    logic [W-1:0] wd;
    logic [1:0]   cmd;
    logic [W-1:0] cnt;
    logic         tick;
    logic         dir;
    logic         mode;
    logic         clr;
    logic [W-1:0] e_cc;
    logic         e_f;
    logic         e_e;
    logic         e_w;
  } vec_t;

  // we, wd, cmd, cnt, tick, dir, mode, clr | cc, flag, evt, wave
  localparam vec_t VEC [0:20] = '{
    '{1'b1, 16'd10, 2'd0, 16'd5,   1'b0, 1'b0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd0,  2'd0, 16'd10,  1'b1, 1'b0, 1'b0, 1'b0, 16'd0,  1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd0,  2'd3, 16'd10,  1'b0, 1'b0, 1'b0, 1'b0, 16'd10, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'd0,  2'd0, 16'd10,  1'b1, 1'b0, 1'b0, 1'b0, 16'd10, 1'b1, 1'b1, 1'b1},
    '{1'b0, 16'd0,  2'd0, 16'd11,  1'b1, 1'b0, 1'b0, 1'b0, 16'd10, 1'b1, 1'b0, 1'b1},
    '{1'b0, 16'd0,  2'd0, 16'd11,  1'b0, 1'b0, 1'b0, 1'b1, 16'd10, 1'b0, 1'b0, 1'b1},
    '{1'b1, 16'd20, 2'd0, 16'd50,  1'b1, 1'b0, 1'b0, 1'b0, 16'd10, 1'b0, 1'b0, 1'b1},
    '{1'b0, 16'd0,  2'd0, 16'd100, 1'b1, 1'b0, 1'b0, 1'b0, 16'd20, 1'b0, 1'b0, 1'b1},
    '{1'b0, 16'd0,  2'd0, 16'd20,  1'b1, 1'b0, 1'b0, 1'b0, 16'd20, 1'b1, 1'b1, 1'b0},
    '{1'b0, 16'd0,  2'd0, 16'd20,  1'b1, 1'b0, 1'b0, 1'b1, 16'd20, 1'b1, 1'b1, 1'b1},
    '{1'b1, 16'd30, 2'd0, 16'd0,   1'b1, 1'b1, 1'b0, 1'b0, 16'd20, 1'b1, 1'b0, 1'b1},
    '{1'b0, 16'd0,  2'd0, 16'd0,   1'b1, 1'b1, 1'b0, 1'b0, 16'd30, 1'b1, 1'b0, 1'b1},
    '{1'b1, 16'd40, 2'd0, 16'd7,   1'b0, 1'b1, 1'b0, 1'b0, 16'd30, 1'b1, 1'b0, 1'b1},
    '{1'b0, 16'd0,  2'd0, 16'd100, 1'b1, 1'b1, 1'b0, 1'b0, 16'd30, 1'b1, 1'b0, 1'b1},
    '{1'b0, 16'd0,  2'd1, 16'd7,   1'b0, 1'b0, 1'b0, 1'b0, 16'd30, 1'b1, 1'b0, 1'b1},
    '{1'b0, 16'd0,  2'd3, 16'd7,   1'b0, 1'b0, 1'b0, 1'b0, 16'd40, 1'b1, 1'b0, 1'b1},
    '{1'b0, 16'd0,  2'd0, 16'd40,  1'b0, 1'b0, 1'b0, 1'b1, 16'd40, 1'b0, 1'b0, 1'b1},
    '{1'b1, 16'd50, 2'd0, 16'd40,  1'b1, 1'b0, 1'b1, 1'b0, 16'd40, 1'b1, 1'b1, 1'b0},
    '{1'b0, 16'd0,  2'd0, 16'd40,  1'b1, 1'b0, 1'b1, 1'b0, 16'd50, 1'b1, 1'b1, 1'b1},
    '{1'b1, 16'd60, 2'd0, 16'd100, 1'b1, 1'b0, 1'b1, 1'b0, 16'd50, 1'b1, 1'b0, 1'b1},
    '{1'b0, 16'd0,  2'd0, 16'd100, 1'b1, 1'b0, 1'b0, 1'b1, 16'd60, 1'b0, 1'b0, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_tick = 0, cnt_down = 0, buf_we = 0, wave_mode = 0, flag_clr = 0;
  logic int_en = 1, evt_en = 1, wave_inv = 0;
  logic [W-1:0] cnt_val = '0, top_val = TOP, buf_wdata = '0;
  logic [1:0] cmd = 2'd0;
  logic [W-1:0] cc_active, period;
  logic match_flag, irq, evt_out, wave_out;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cmp_wave_chan #(.W(W)) i_cmp_wave_chan (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_val(cnt_val),
    .cnt_down(cnt_down), .top_val(top_val), .buf_we(buf_we), .buf_wdata(buf_wdata),
    .cmd(cmd), .wave_mode(wave_mode), .flag_clr(flag_clr), .int_en(int_en),
    .evt_en(evt_en), .wave_inv(wave_inv), .cc_active(cc_active), .period(period),
    .match_flag(match_flag), .irq(irq), .evt_out(evt_out), .wave_out(wave_out)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic quiet();
    buf_we = 0; cmd = 2'd0; cnt_tick = 0; flag_clr = 0;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset cc_active", cc_active, '0);
    chk("R1 reset match_flag", W'(match_flag), '0);
    chk("R1 reset evt_out", W'(evt_out), '0);
    chk("R1 reset wave_out", W'(wave_out), '0);
    @(negedge clk) rst_n = 1'b1;

    foreach (VEC[i]) begin
      @(negedge clk);
      buf_we = VEC[i].we; buf_wdata = VEC[i].wd; cmd = VEC[i].cmd;
      cnt_val = VEC[i].cnt; cnt_tick = VEC[i].tick; cnt_down = VEC[i].dir;
      wave_mode = VEC[i].mode; flag_clr = VEC[i].clr;
      @(posedge clk);
      #1;
      chk($sformatf("R2 R3 R4 cc_active row %0d", i), cc_active, VEC[i].e_cc);
      chk($sformatf("R5 period row %0d", i), period, VEC[i].mode ? VEC[i].e_cc : TOP);
      chk($sformatf("R6 R7 match_flag row %0d", i), W'(match_flag), W'(VEC[i].e_f));
      chk($sformatf("R8 irq row %0d", i), W'(irq), W'(VEC[i].e_f));
      chk($sformatf("R8 evt_out row %0d", i), W'(evt_out), W'(VEC[i].e_e));
      chk($sformatf("R9 wave_out row %0d", i), W'(wave_out), W'(VEC[i].e_w));
    end

    // R9: inversion acts on the output at once, state is 1 here
    @(negedge clk); quiet(); wave_mode = 0; wave_inv = 1;
    #1 chk("R9 inverted wave_out", W'(wave_out), '0);
    @(negedge clk); wave_inv = 0;

    // R8: disabled interrupt and event still let the flag set
    int_en = 0; evt_en = 0; cnt_val = 16'd60; cnt_tick = 1;
    @(posedge clk); #1;
    chk("R8 irq masked", W'(irq), '0);
    chk("R8 evt masked", W'(evt_out), '0);
    chk("R6 flag set while masked", W'(match_flag), 16'd1);
    chk("R9 toggle while masked", W'(wave_out), '0);
    @(negedge clk); quiet(); int_en = 1;
    #1 chk("R8 irq after enable", W'(irq), 16'd1);

    // R6: counter equal to compare without a tick is not a match
    flag_clr = 1;
    @(negedge clk); flag_clr = 0; cnt_val = 16'd60; cnt_tick = 0;
    @(posedge clk); #1;
    chk("R6 no tick no flag", W'(match_flag), '0);
    chk("R9 no tick no toggle", W'(wave_out), '0);

    // R8: event is one cycle wide, evt_en back on
    @(negedge clk); evt_en = 1; cnt_tick = 1;
    @(posedge clk); #1 chk("R8 evt pulse high", W'(evt_out), 16'd1);
    @(negedge clk); cnt_tick = 0;
    @(posedge clk); #1 chk("R8 evt pulse ends", W'(evt_out), '0);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    chk("R1 rerun reset cc_active", cc_active, '0);
    chk("R1 rerun reset flag", W'(match_flag), '0);
    chk("R1 rerun reset wave", W'(wave_out), '0);
    @(negedge clk); rst_n = 1; cmd = 2'd3;
    @(posedge clk); #1 chk("R1 R3 buffer cleared by reset", cc_active, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule